// File: doc/BRIEF.md
# Random number generator register controller

This block is the register front end of a true random number generator. An external entropy source supplies a 32-bit raw word with a valid strobe. The controller decides when a word may be accepted, copies it into an output data register and raises a ready flag. A separate input reports that a key transfer over the private key bus has finished, and the controller keeps that event as a second flag. One interrupt line combines both flags with a software-controlled mask.

Software reaches the block through a small word-addressed register port. The port has a read strobe, a write strobe, a 3-bit word index and combinational read data. A keyed control register starts and stops generation. A mode register selects full or half delivery rate. The mask is set through one address and cleared through another, and can be read back at a third. The status register clears its flags when it is read. The data register holds the most recent accepted word.

Top module: `rng_ctl_regs`

## Requirements
- R1: After reset, enable, mode, mask, status, data and `irq_o` are all zero. While enable (control register bit 0, word index 0) is clear, no word is accepted.
- R2: With the mode bit clear, the first word is accepted on the 84th rising edge after the edge that sets enable. Later words follow every 84 edges while `ent_valid_i` stays high.
- R3: With the mode bit set (mode register bit 0, word index 1), the interval in R2 becomes 168 edges.
- R4: An accepted word is stored in the data register (word index 6), and the ready flag (status bit 0, word index 5) is set at the same edge.
- R5: A high `key_done_i` at a rising edge sets the transfer-complete flag (status bit 1).
- R6: `irq_o` is high exactly when some status flag is set and its mask bit (same bit position) is set.
- R7: A read of the status register returns the flags and clears them at that edge. A flag that is set at the same edge stays set.
- R8: Writing to word index 2 sets every mask bit written as 1. Writing to word index 3 clears every mask bit written as 1. Zero bits leave the mask unchanged. Word index 4 reads the mask.
- R9: A word accepted while ready is still set overwrites the data register, and ready stays set.
- R10: Clearing enable returns the pacing count to zero, so a later enable waits a full interval. Clearing enable does not clear the ready flag.
- R11: A control write changes enable only when bits 31:8 equal the key 0x5A17C3. With any other key, the write is ignored.
- R12: When the interval has elapsed but `ent_valid_i` is low, acceptance waits for the first edge with `ent_valid_i` high. The next interval then counts from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe (side effects on status) |
| bus_addr_i | input | 3 | Word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from index |
| ent_data_i | input | 32 | Raw random word from the entropy source |
| ent_valid_i | input | 1 | Raw word is valid |
| key_done_i | input | 1 | Key transfer finished pulse |
| irq_o | output | 1 | Interrupt line |

## Verification
Delivery timing is swept over both rate modes. Each mode is first measured from the enabling edge, which confirms that the counter starts from zero. Later intervals are measured between consecutive accepted words, which confirms that the counter reloads after each acceptance. A stalled valid strobe shows that the counter holds on an expired interval instead of wrapping. An enable pulse cut short before the interval ends, followed by a fresh enable, shows whether the count is reset or kept. Two patterns separate set-before-clear from clear-before-set on the flags and show that zero mask bits are ignored: mask writes mixing ones and zeros, and a transfer pulse that coincides with a status read.

// File: rtl/rng_ctl_pkg.sv
package rng_ctl_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NFLAG  = 2;
  localparam int unsigned F_RDY  = 0;
  localparam int unsigned F_XFER = 1;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_MODE  = 3'd1,
    A_IEN   = 3'd2,
    A_IDIS  = 3'd3,
    A_IMASK = 3'd4,
    A_STAT  = 3'd5,
    A_DATA  = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/rng_pacer.sv
module rng_pacer #(
  parameter int unsigned BASE = 84,
  localparam int unsigned CW  = $clog2(2 * BASE)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic half_i,
  input  logic valid_i,
  output logic load_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;
  logic          due;

  assign last   = half_i ? CW'(2 * BASE - 1) : CW'(BASE - 1);
  assign due    = cnt_q >= last;  // >= covers a mode drop mid-count
  assign load_o = en_i && due && valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (due)    cnt_q <= valid_i ? '0 : cnt_q;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // checker-side gap counter since the previous load
  logic [CW:0] gap_q;
  logic        seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (load_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q < (CW+1)'(2 * BASE)) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  AST_MIN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && seen_q) |-> (gap_q >= (CW+1)'(BASE - 1))) else $error("gap"); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0)) else $error("idle cnt"); // R10
endmodule

// File: rtl/rng_flags.sv
module rng_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  input  logic         ien_we_i,
  input  logic         idis_we_i,
  input  logic [N-1:0] wmask_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] flags_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~{N{clr_i}}) | set_i;  // set wins
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (ien_we_i)  mask_q <= mask_q | wmask_i;
    else if (idis_we_i) mask_q <= mask_q & ~wmask_i;
  end

  assign flags_o = flags_q;
  assign mask_o  = mask_q;
  assign irq_o   = |(flags_q & mask_q);

  for (genvar b = 0; b < N; b++) begin : g_chk
    AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[b] |=> flags_o[b]) else $error("flag set"); // R4
  end
  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i == '0) |=> (flags_o == '0 && !irq_o)) else $error("clear"); // R7
  AST_W1S: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien_we_i |=> ((mask_o & $past(wmask_i)) == $past(wmask_i))) else $error("w1s"); // R8
  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idis_we_i && !ien_we_i) |=> ((mask_o & $past(wmask_i)) == '0)) else $error("w1c"); // R8
endmodule

// File: rtl/rng_ctl_regs.sv
module rng_ctl_regs
  import rng_ctl_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned BASE  = 84,
  parameter int unsigned KEY_W = DW - 8,
  parameter logic [KEY_W-1:0] CTRL_KEY = KEY_W'(24'h5A17C3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  input  logic [DW-1:0]     ent_data_i,
  input  logic              ent_valid_i,
  input  logic              key_done_i,
  output logic              irq_o
);
  logic            en_q, half_q, load;
  logic [DW-1:0]   data_q;
  logic [NFLAG-1:0] flags, mask, set_v;
  logic            key_ok, ctrl_we;

  assign key_ok  = bus_wdata_i[DW-1:DW-KEY_W] == CTRL_KEY;
  assign ctrl_we = bus_we_i && bus_addr_i == A_CTRL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      half_q <= 1'b0;
    end else begin
      if (ctrl_we && key_ok)                 en_q   <= bus_wdata_i[0];
      if (bus_we_i && bus_addr_i == A_MODE)  half_q <= bus_wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_q <= '0;
    else if (load) data_q <= ent_data_i;
  end

  rng_pacer #(.BASE(BASE)) u_pacer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_q),
    .half_i  (half_q),
    .valid_i (ent_valid_i),
    .load_o  (load)
  );

  always_comb begin
    set_v         = '0;
    set_v[F_RDY]  = load;
    set_v[F_XFER] = key_done_i;
  end

  rng_flags #(.N(NFLAG)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_v),
    .clr_i     (bus_re_i && bus_addr_i == A_STAT),
    .ien_we_i  (bus_we_i && bus_addr_i == A_IEN),
    .idis_we_i (bus_we_i && bus_addr_i == A_IDIS),
    .wmask_i   (bus_wdata_i[NFLAG-1:0]),
    .flags_o   (flags),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_CTRL:  bus_rdata_o[0] = en_q;
      A_MODE:  bus_rdata_o[0] = half_q;
      A_IMASK: bus_rdata_o[NFLAG-1:0] = mask;
      A_STAT:  bus_rdata_o[NFLAG-1:0] = flags;
      A_DATA:  bus_rdata_o = data_q;
      default: bus_rdata_o = '0;
    endcase
  end

  AST_BAD_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we && !key_ok) |=> $stable(en_q)) else $error("key"); // R11
  AST_DATA_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (data_q == $past(ent_data_i) && flags[F_RDY])) else $error("load"); // R4
  AST_OFF_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !key_done_i && bus_re_i && bus_addr_i == A_STAT) |=> !flags[F_RDY]) else $error("off"); // R1
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o) else $error("irq"); // R6
endmodule

// File: tb/rng_ctl_regs_test.sv
module rng_ctl_regs_test;
  localparam int P = 84;
  localparam logic [23:0] KEY = 24'h5A17C3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 0, re = 0, valid = 1, kd = 0, irq;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0, rdata, ent = 0;
  logic drv_valid = 1, drv_kd = 0;
  logic [31:0] lfsr = 32'hACE1_2345;
  logic [31:0] hist [0:511];
  logic [31:0] rd_s;
  logic irq_s;
  int cyc = 0, total = 0, bad = 0;

  always #5 clk = ~clk;

  rng_ctl_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ent_data_i(ent), .ent_valid_i(valid),
    .key_done_i(kd), .irq_o(irq)
  );

  task automatic op(input logic w, input logic r, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = w; re = r; addr = a; wdata = d; valid = drv_valid; kd = drv_kd;
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    ent = lfsr;
    hist[cyc % 512] = lfsr;
    cyc++;
    #4;
    rd_s = rdata; irq_s = irq;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poll(input int max, output int k);
    k = -1;
    for (int i = 0; i < max; i++) begin
      op(0, 1, 3'd5, 0);
      if (rd_s[0]) begin k = cyc - 1; return; end
    end
  endtask

  task automatic ctrl(input logic e, output int c);
    op(1, 0, 3'd0, {KEY, 7'd0, e});
    c = cyc - 1;
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c, k, k2, pm;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    op(0, 0, 3'd0, 0); chk("R1 irq", {31'd0, irq_s}, 0); chk("R1 ctrl", rd_s, 0);
    op(0, 0, 3'd1, 0); chk("R1 mode", rd_s, 0);
    op(0, 0, 3'd4, 0); chk("R1 mask", rd_s, 0);
    op(0, 0, 3'd6, 0); chk("R1 data", rd_s, 0);
    op(0, 1, 3'd5, 0); chk("R1 status", rd_s, 0);

    // R11 wrong key ignored
    op(1, 0, 3'd0, {24'h5A17C2, 8'h01});
    op(0, 0, 3'd0, 0); chk("R11 ctrl after bad key", rd_s, 0);
    poll(2 * P, k); chk("R11 R1 no word while off", k, -1);

    // R2 / R3 sweep over both rates
    for (int m = 0; m < 2; m++) begin
      pm = P * (m + 1);
      op(1, 0, 3'd1, m);
      op(0, 0, 3'd1, 0); chk("R3 mode readback", rd_s, m);
      ctrl(1, c);
      poll(2 * pm + 10, k);
      chk(m ? "R3 first interval" : "R2 first interval", k - c, pm + 1);
      op(0, 1, 3'd5, 0); chk("R7 ready cleared by read", rd_s[0], 0);
      op(0, 0, 3'd6, 0); chk("R4 data", rd_s, hist[(k - 1) % 512]);
      for (int n = 0; n < 2; n++) begin
        poll(2 * pm + 10, k2);
        chk(m ? "R3 interval" : "R2 interval", k2 - k, pm);
        op(0, 0, 3'd6, 0); chk("R4 data next", rd_s, hist[(k2 - 1) % 512]);
        k = k2;
      end
      ctrl(0, c);
    end
    op(1, 0, 3'd1, 0);

    // R12 stalled valid
    drv_valid = 0;
    ctrl(1, c);
    poll(P + 30, k); chk("R12 no word without valid", k, -1);
    drv_valid = 1;
    c = cyc;
    poll(5, k); chk("R12 accept on first valid", k - c, 1);
    poll(2 * P, k2); chk("R12 interval restarts", k2 - k, P);
    ctrl(0, c);

    // R10 counter reset and ready kept
    op(0, 1, 3'd5, 0);
    ctrl(1, c);
    repeat (50) op(0, 0, 3'd0, 0);
    ctrl(0, c);
    op(0, 1, 3'd5, 0); chk("R10 no word in short enable", rd_s[0], 0);
    ctrl(1, c);
    poll(2 * P, k); chk("R10 full interval after re-enable", k - c, P + 1);
    repeat (P + 5) op(0, 0, 3'd0, 0);
    ctrl(0, c);
    op(0, 1, 3'd5, 0); chk("R10 ready kept after disable", rd_s[0], 1);

    // R9 overwrite while ready set
    ctrl(1, c);
    repeat (2 * P + 3) op(0, 0, 3'd0, 0);
    ctrl(0, k);
    op(0, 1, 3'd5, 0); chk("R9 ready stays set", rd_s[0], 1);
    op(0, 0, 3'd6, 0); chk("R9 data overwritten", rd_s, hist[(c + 2 * P) % 512]);

    // R8 / R5 / R6 / R7 mask and interrupt
    op(1, 0, 3'd2, 0); op(0, 0, 3'd4, 0); chk("R8 zero set no effect", rd_s, 0);
    op(1, 0, 3'd2, 2); op(0, 0, 3'd4, 0); chk("R8 set bit1", rd_s, 2);
    drv_kd = 1; op(0, 0, 3'd0, 0); drv_kd = 0;
    op(0, 1, 3'd5, 0);
    chk("R5 xfer flag", rd_s, 2); chk("R6 irq on xfer", irq_s, 1);
    op(0, 0, 3'd0, 0); chk("R7 irq cleared by read", irq_s, 0);
    op(1, 0, 3'd2, 3); op(1, 0, 3'd3, 0);
    op(0, 0, 3'd4, 0); chk("R8 zero clear no effect", rd_s, 3);
    op(1, 0, 3'd3, 1); op(0, 0, 3'd4, 0); chk("R8 clear bit0", rd_s, 2);
    drv_kd = 1; op(0, 1, 3'd5, 0); drv_kd = 0;
    op(0, 1, 3'd5, 0); chk("R7 set wins over read clear", rd_s, 2);
    ctrl(1, c);
    repeat (P + 2) op(0, 0, 3'd0, 0);
    ctrl(0, c);
    chk("R6 masked ready no irq", irq_s, 0);
    op(1, 0, 3'd2, 1);
    op(0, 0, 3'd0, 0); chk("R6 irq after unmask", irq_s, 1);
    op(1, 0, 3'd3, 1);
    op(0, 0, 3'd0, 0); chk("R6 irq after mask clear", irq_s, 0);
    op(0, 1, 3'd5, 0); chk("R4 ready pending", rd_s, 1);
    op(0, 0, 3'd5, 0); chk("R7 status after read", rd_s, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule